// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order pipeline and decides, for each of the two ALU operands, where the operand value comes from. It compares the two source register numbers of the instruction now in execute with the destination register numbers of the two older instructions still in flight. One is in the memory-access stage and one is in the write-back stage. It issues a 2-bit select code per operand that steers the operand multiplexer in front of the ALU.

A result produced by the instruction one ahead, or two ahead, can then feed the current instruction without waiting for the register file write. The block is purely combinational and holds no state. When both older instructions target the same register, the one closer to execute is newer and wins. A stage only counts when it will really write a register. Register zero is always zero and is never bypassed.

Top module: `fwd_unit`

## Requirements
- R1: `sel_a` is 2'b10 (memory-stage bypass) when `exm_wen` is 1, `exm_dst` is non-zero and `exm_dst` equals `src_a_idx`.
- R2: `sel_b` is 2'b10 when `exm_wen` is 1, `exm_dst` is non-zero and `exm_dst` equals `src_b_idx`.
- R3: `sel_a` is 2'b01 (write-back-stage bypass) when `mwb_wen` is 1, `mwb_dst` is non-zero, `mwb_dst` equals `src_a_idx`, and R1 does not apply.
- R4: `sel_b` is 2'b01 when `mwb_wen` is 1, `mwb_dst` is non-zero, `mwb_dst` equals `src_b_idx`, and R2 does not apply.
- R5: When both stages match the same operand, that operand selects 2'b10, because the memory-stage value is newer.
- R6: A stage whose write-enable is 0 never causes a bypass, even when its destination number matches.
- R7: A destination register number of 0 never causes a bypass, so a source index of 0 always yields 2'b00.
- R8: In every other case an operand selects 2'b00 (register file). The code 2'b11 never appears. Each operand is decided on its own, so the two selects may differ.
- R9: The selects are a pure function of the current inputs. An input change shows on the outputs in the same cycle, and earlier inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_idx | input | 5 | First source register number of the instruction in execute |
| src_b_idx | input | 5 | Second source register number of the instruction in execute |
| exm_dst | input | 5 | Destination register number of the instruction in the memory stage |
| exm_wen | input | 1 | Register-write enable of the instruction in the memory stage |
| mwb_dst | input | 5 | Destination register number of the instruction in the write-back stage |
| mwb_wen | input | 1 | Register-write enable of the instruction in the write-back stage |
| sel_a | output | 2 | Source select for operand A: 00 register file, 10 memory stage, 01 write-back stage |
| sel_b | output | 2 | Source select for operand B, same encoding |

## Verification
The two bypass paths can both be valid for one operand in the same cycle. This happens when back-to-back older instructions write the register the current instruction reads. The bench provokes it by giving both stages a matching destination with write enabled, and it expects the memory-stage code. It also sets cases where one operand matches only the memory stage and the other matches only the write-back stage, which shows that the priority is applied to each operand on its own. A clear write-enable or a zero destination on the newer stage must let the older stage's match through.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source codes; bit positions are decoded by the operand mux.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_MWB = 2'b01,
        SEL_EXM = 2'b10
    } fwd_sel_e;

    // Producing stages in priority order: index 0 is the newest.
    localparam int STAGE_CNT = 2;
    localparam int OP_CNT    = 2;

    function automatic fwd_sel_e stage_code(input int stg);
        fwd_sel_e code;
        if (stg == 0) code = SEL_EXM;
        else          code = SEL_MWB;
        return code;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_idx,
    input  logic [REG_W-1:0] dst_idx,
    input  logic             dst_wen,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic dst_live;
    logic idx_eq;

    always_comb begin
        dst_live = dst_wen && (dst_idx != ZERO_REG);
        idx_eq   = (dst_idx == src_idx);
        hit      = dst_live && idx_eq;
    end

endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
    import fwd_pkg::*;
#(
    parameter int N_STG = STAGE_CNT
) (
    input  logic [N_STG-1:0] hits,
    output fwd_sel_e         sel
);
    // Walk from oldest to newest so the newest match is written last.
    always_comb begin
        sel = SEL_RF;
        for (int s = N_STG - 1; s >= 0; s--) begin
            if (hits[s]) sel = stage_code(s);
        end
    end

    // R5
    newest_wins_chk: assert final (!hits[0] || sel == SEL_EXM);

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_a_idx,
    input  logic [REG_W-1:0] src_b_idx,
    input  logic [REG_W-1:0] exm_dst,
    input  logic             exm_wen,
    input  logic [REG_W-1:0] mwb_dst,
    input  logic             mwb_wen,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [REG_W-1:0] op_src  [OP_CNT];
    logic [REG_W-1:0] stg_dst [STAGE_CNT];
    logic             stg_wen [STAGE_CNT];
    fwd_sel_e         op_sel  [OP_CNT];

    always_comb begin
        op_src[0]  = src_a_idx;
        op_src[1]  = src_b_idx;
        stg_dst[0] = exm_dst;
        stg_wen[0] = exm_wen;
        stg_dst[1] = mwb_dst;
        stg_wen[1] = mwb_wen;
    end

    for (genvar op = 0; op < OP_CNT; op++) begin : g_op
        logic [STAGE_CNT-1:0] hits;
        for (genvar st = 0; st < STAGE_CNT; st++) begin : g_stg
            fwd_match #(.REG_W(REG_W)) u_match (
                .src_idx (op_src[op]),
                .dst_idx (stg_dst[st]),
                .dst_wen (stg_wen[st]),
                .hit     (hits[st])
            );
        end
        fwd_prio #(.N_STG(STAGE_CNT)) u_prio (
            .hits (hits),
            .sel  (op_sel[op])
        );
    end

    assign sel_a = op_sel[0];
    assign sel_b = op_sel[1];

    // R1
    a_exm_src_chk: assert final (sel_a != 2'b10 ||
        (exm_wen && exm_dst != ZERO_REG && exm_dst == src_a_idx));
    // R2
    b_exm_src_chk: assert final (sel_b != 2'b10 ||
        (exm_wen && exm_dst != ZERO_REG && exm_dst == src_b_idx));
    // R3
    a_mwb_src_chk: assert final (sel_a != 2'b01 ||
        (mwb_wen && mwb_dst != ZERO_REG && mwb_dst == src_a_idx));
    // R4
    b_mwb_src_chk: assert final (sel_b != 2'b01 ||
        (mwb_wen && mwb_dst != ZERO_REG && mwb_dst == src_b_idx));
    // R6
    no_wen_chk: assert final ((exm_wen || mwb_wen) ||
        (sel_a == 2'b00 && sel_b == 2'b00));
    // R7
    zero_src_chk: assert final ((src_a_idx != ZERO_REG || sel_a == 2'b00) &&
        (src_b_idx != ZERO_REG || sel_b == 2'b00));
    // R8
    legal_code_chk: assert final (sel_a != 2'b11 && sel_b != 2'b11);

endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;

    typedef struct {
        logic [1:0] exp_a;
        logic [1:0] exp_b;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] src_a_idx = '0;
    logic [4:0] src_b_idx = '0;
    logic [4:0] exm_dst = '0;
    logic       exm_wen = 1'b0;
    logic [4:0] mwb_dst = '0;
    logic       mwb_wen = 1'b0;
    logic [1:0] sel_a;
    logic [1:0] sel_b;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb[$];

    always #10 clk = ~clk;

    fwd_unit uut (
        .src_a_idx (src_a_idx),
        .src_b_idx (src_b_idx),
        .exm_dst   (exm_dst),
        .exm_wen   (exm_wen),
        .mwb_dst   (mwb_dst),
        .mwb_wen   (mwb_wen),
        .sel_a     (sel_a),
        .sel_b     (sel_b)
    );

    function automatic logic [1:0] ref_sel(input logic [4:0] src,
                                           input logic [4:0] ed, input logic ew,
                                           input logic [4:0] md, input logic mw);
        if (ew && ed != 5'd0 && ed == src) return 2'b10;
        if (mw && md != 5'd0 && md == src) return 2'b01;
        return 2'b00;
    endfunction

    task automatic drive(input logic [4:0] sa, input logic [4:0] sbi,
                         input logic [4:0] ed, input logic ew,
                         input logic [4:0] md, input logic mw, input string req);
        item_t it;
        @(posedge clk);
        src_a_idx = sa;  src_b_idx = sbi;
        exm_dst = ed;    exm_wen = ew;
        mwb_dst = md;    mwb_wen = mw;
        it.exp_a = ref_sel(sa, ed, ew, md, mw);
        it.exp_b = ref_sel(sbi, ed, ew, md, mw);
        it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compares half a cycle after each drive edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (sel_a !== it.exp_a) begin
                errors++;
                $display("FAIL %s operand A: got %b expected %b", it.req, sel_a, it.exp_a);
            end
            checks++;
            if (sel_b !== it.exp_b) begin
                errors++;
                $display("FAIL %s operand B: got %b expected %b", it.req, sel_b, it.exp_b);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: all-zero inputs give register-file selects (R8)
        drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, "R8 reset");
        drive(5'd3, 5'd4, 5'd3, 1'b1, 5'd0, 1'b0, "R1");
        drive(5'd2, 5'd7, 5'd7, 1'b1, 5'd1, 1'b1, "R2");
        drive(5'd9, 5'd4, 5'd5, 1'b1, 5'd9, 1'b1, "R3");
        drive(5'd1, 5'd12, 5'd0, 1'b0, 5'd12, 1'b1, "R4");
        drive(5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1, "R5 both stages");
        drive(5'd6, 5'd8, 5'd8, 1'b1, 5'd6, 1'b1, "R5 split sources");
        drive(5'd11, 5'd11, 5'd11, 1'b0, 5'd11, 1'b1, "R6 newer disabled");
        drive(5'd11, 5'd14, 5'd11, 1'b0, 5'd14, 1'b0, "R6 both disabled");
        drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, "R7 zero register");
        drive(5'd4, 5'd0, 5'd0, 1'b1, 5'd4, 1'b1, "R7 zero newer dst");
        drive(5'd31, 5'd31, 5'd31, 1'b1, 5'd2, 1'b1, "R8 max index");
        drive(5'd17, 5'd18, 5'd19, 1'b1, 5'd20, 1'b1, "R8 no match");
        // R9: fresh vectors every cycle, no dependence on history
        for (int i = 0; i < 400; i++) begin
            logic [4:0] r_sa, r_sb, r_ed, r_md;
            r_sa = 5'($urandom_range(0, 7));
            r_sb = 5'($urandom_range(0, 7));
            r_ed = 5'($urandom_range(0, 7));
            r_md = 5'($urandom_range(0, 7));
            drive(r_sa, r_sb, r_ed, 1'($urandom), r_md, 1'($urandom), "R9 sweep");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule